// File: doc/BRIEF.md
# Receive idle time-out counter

This block is a 16-bit down-counter that watches for a gap in the receive data stream. In its time-out mode, the counter is not started or stopped by software. Instead, every character that the receiver writes into its FIFO restarts the count from a programmed preset. If the count runs out before the next character arrives, a counter-ready flag sets. The flag can raise an interrupt under a mask bit. Software uses this to learn that a message has ended and that characters are still waiting in the FIFO, or that the line has been quiet for longer than the preset interval.

Outside time-out mode the same counter runs as a plain software-controlled down-counter. A start request loads the preset and runs the counter, and a stop request halts it and clears the flag. The counter advances only on cycles where the counter clock enable is high. The current value can be read at any time as two bytes.

A command field (bits 7:4 of the command byte) arms or disarms time-out mode. Arming clears the flag and parks the counter until the first character arrives. A character that arrives after a time-out withdraws the flag and the interrupt.

Top module: `idle_tmr`

## Requirements
- R1: After reset the ready flag, the interrupt and both count bytes are 0, and time-out mode is off.
- R2: A command write whose field `cmdOp` equals 4'hA turns time-out mode on, clears the ready flag and stops the counter. The count then holds through any number of enabled ticks until a character strobe arrives.
- R3: In time-out mode, a character strobe stops the counter. The first enabled tick after the strobe reloads the count from {presetHi, presetLo}, and each later enabled tick decrements it by one.
- R4: The running tick that finds the count at 1 or 0 sets the ready flag and leaves the count at 0. From then on the count holds at 0 and the counter stays stopped until a reload.
- R5: `irqOut` equals the ready flag ANDed with `irqMask` in the same cycle.
- R6: In time-out mode, a character strobe clears the ready flag on the next clock. A strobe that arrives while the counter is running restarts the reload sequence.
- R7: While time-out mode is on, `startCmd` and `stopCmd` change neither the count nor the ready flag.
- R8: A command write with `cmdOp` equal to 4'hC turns time-out mode off and stops the counter. After that, character strobes are ignored and start and stop act again.
- R9: Outside time-out mode, `startCmd` loads the preset on the next clock and runs the counter on enabled ticks. `stopCmd` stops the counter and clears the ready flag.
- R10: A recognised command write (4'hA or 4'hC) takes precedence over a character strobe, a start or a stop in the same cycle. A stop takes precedence over a start in the same cycle.
- R11: `countHi` shows count bits 15:8 and `countLo` shows bits 7:0. Both are registered and change in the cycle after the event that updates the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter clock enable, one cycle per counter tick |
| presetHi | input | 8 | Upper preset byte |
| presetLo | input | 8 | Lower preset byte |
| charPush | input | 1 | A received character was written into the FIFO this cycle |
| cmdWe | input | 1 | Command write strobe |
| cmdOp | input | 4 | Command field (bits 7:4 of the command byte) |
| irqMask | input | 1 | Interrupt mask for the ready flag (1 = enabled) |
| startCmd | input | 1 | Start-counter request |
| stopCmd | input | 1 | Stop-counter request |
| ctrReady | output | 1 | Counter-ready flag |
| irqOut | output | 1 | Masked interrupt |
| countHi | output | 8 | Live count, upper byte |
| countLo | output | 8 | Live count, lower byte |

## Verification
A wrong controller state shows up at the count bytes within one enabled tick. A counter wrongly left running decrements where it should hold, and one wrongly left stopped fails to reload. A mode bit that is out of step makes a start, stop or character strobe act when it should be ignored, or be ignored when it should act, and the count or flag differs on the next clock. A reload that is off by one tick, or an expiry at the wrong count, moves the rise of the ready flag and the interrupt by a cycle. The per-cycle comparison against the behavioural model therefore catches it at the first wrong edge.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;

  localparam logic [3:0] CMD_TMO_ON  = 4'hA;
  localparam logic [3:0] CMD_TMO_OFF = 4'hC;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } tmrState_t;

  typedef struct packed {
    logic load;
    logic dec;
    logic clr;
  } tmrStrobe_t;

endpackage

// File: rtl/idle_tmr_dp.sv
module idle_tmr_dp
  import idle_tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [BYTE_W-1:0] presetHi,
  input  logic [BYTE_W-1:0] presetLo,
  output logic [BYTE_W-1:0] countHi,
  output logic [BYTE_W-1:0] countLo,
  output logic              cntLow
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= {presetHi, presetLo};
    end else if (strobe.clr) begin
      count <= '0;
    end else if (strobe.dec) begin
      count <= count - CNT_W'(1);
    end
  end

  assign cntLow  = (count <= CNT_W'(1));
  assign countHi = count[CNT_W-1:BYTE_W];
  assign countLo = count[BYTE_W-1:0];

  // R3: a load strobe places the preset in the count on the next edge
  assert_load_takes_preset_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == $past({presetHi, presetLo})));

  // R4: an expired count stays at zero until the next load
  assert_zero_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !strobe.load) |=> (count == '0));

  // R4: the control never decrements through zero
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> (count > CNT_W'(1)));

endmodule

// File: rtl/idle_tmr_ctrl.sv
module idle_tmr_ctrl
  import idle_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       charPush,
  input  logic       cmdWe,
  input  logic [3:0] cmdOp,
  input  logic       startCmd,
  input  logic       stopCmd,
  input  logic       cntLow,
  output tmrStrobe_t strobe,
  output logic       ready
);

  tmrState_t state, nextState;
  logic      toMode, nextMode, nextReady;
  logic      cmdOn, cmdOff, doTick;

  assign cmdOn  = cmdWe && (cmdOp == CMD_TMO_ON);
  assign cmdOff = cmdWe && (cmdOp == CMD_TMO_OFF);

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextReady = ready;
    nextMode  = toMode;
    doTick    = 1'b0;
    if (cmdOn) begin
      nextMode  = 1'b1;
      nextReady = 1'b0;
      nextState = ST_IDLE;
    end else if (cmdOff) begin
      nextMode  = 1'b0;
      nextState = ST_IDLE;
    end else if (toMode) begin
      if (charPush) begin
        nextState = ST_PEND;
        nextReady = 1'b0;
      end else begin
        doTick = tickEn;
      end
    end else begin
      if (stopCmd) begin
        nextState = ST_IDLE;
        nextReady = 1'b0;
      end else if (startCmd) begin
        strobe.load = 1'b1;
        nextState   = ST_RUN;
      end else begin
        doTick = tickEn;
      end
    end

    if (doTick) begin
      case (state)
        ST_PEND: begin
          strobe.load = 1'b1;
          nextState   = ST_RUN;
        end
        ST_RUN: begin
          if (cntLow) begin
            strobe.clr = 1'b1;
            nextReady  = 1'b1;
            nextState  = ST_IDLE;
          end else begin
            strobe.dec = 1'b1;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      toMode <= 1'b0;
      ready  <= 1'b0;
    end else begin
      state  <= nextState;
      toMode <= nextMode;
      ready  <= nextReady;
    end
  end

  // R4: the flag only rises after a running tick
  assert_ready_rise_on_expiry_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(state == ST_RUN && tickEn));

  // R2: arming clears the flag and parks the counter
  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdOn |=> (!ready && state == ST_IDLE && toMode));

  // R6: a character in time-out mode withdraws the flag and begins the reload
  assert_push_withdraws_R6: assert property (@(posedge clk) disable iff (!rstN)
    (toMode && charPush && !cmdOn && !cmdOff) |=> (!ready && state == ST_PEND));

  // R7: start and stop have no effect in time-out mode
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (toMode && (startCmd || stopCmd) && !cmdOn && !cmdOff && !charPush && !tickEn)
      |=> ($stable(state) && $stable(ready)));

  // R8: disarming leaves the mode off and the counter stopped
  assert_disarm_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdOff |=> (!toMode && state == ST_IDLE));

endmodule

// File: rtl/idle_tmr.sv
module idle_tmr
  import idle_tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [BYTE_W-1:0] presetHi,
  input  logic [BYTE_W-1:0] presetLo,
  input  logic              charPush,
  input  logic              cmdWe,
  input  logic [3:0]        cmdOp,
  input  logic              irqMask,
  input  logic              startCmd,
  input  logic              stopCmd,
  output logic              ctrReady,
  output logic              irqOut,
  output logic [BYTE_W-1:0] countHi,
  output logic [BYTE_W-1:0] countLo
);

  tmrStrobe_t strobe;
  logic       cntLow;

  idle_tmr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .charPush (charPush),
    .cmdWe    (cmdWe),
    .cmdOp    (cmdOp),
    .startCmd (startCmd),
    .stopCmd  (stopCmd),
    .cntLow   (cntLow),
    .strobe   (strobe),
    .ready    (ctrReady)
  );

  idle_tmr_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .presetHi (presetHi),
    .presetLo (presetLo),
    .countHi  (countHi),
    .countLo  (countLo),
    .cntLow   (cntLow)
  );

  assign irqOut = ctrReady & irqMask;

  // R5: the interrupt can only be high while the flag is set
  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ctrReady);

endmodule

// File: tb/sim_idle_tmr.sv
module sim_idle_tmr;

  localparam int CLK_PERIOD = 10;
  localparam int WATCH_LIMIT = 50000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0, charPush = 1'b0, cmdWe = 1'b0;
  logic [3:0] cmdOp = 4'h0;
  logic       startCmd = 1'b0, stopCmd = 1'b0, irqMask = 1'b0;
  logic [7:0] presetHi = 8'h00, presetLo = 8'h00;
  logic       ctrReady, irqOut;
  logic [7:0] countHi, countLo;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural reference
  bit mMode = 0, mRdy = 0;
  int mPhase = 0;   // 0 stopped, 1 awaiting reload tick, 2 counting
  int mCnt = 0;

  idle_tmr u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .presetHi(presetHi), .presetLo(presetLo),
    .charPush(charPush), .cmdWe(cmdWe), .cmdOp(cmdOp), .irqMask(irqMask),
    .startCmd(startCmd), .stopCmd(stopCmd), .ctrReady(ctrReady), .irqOut(irqOut),
    .countHi(countHi), .countLo(countLo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    int pre;
    bit tickUse;
    pre = presetHi * 256 + presetLo;
    tickUse = 0;
    if (!rstN) begin
      mMode = 0; mRdy = 0; mPhase = 0; mCnt = 0;
    end else if (cmdWe && cmdOp == 4'hA) begin
      mMode = 1; mRdy = 0; mPhase = 0;
    end else if (cmdWe && cmdOp == 4'hC) begin
      mMode = 0; mPhase = 0;
    end else if (mMode) begin
      if (charPush) begin mPhase = 1; mRdy = 0; end
      else tickUse = tickEn;
    end else begin
      if (stopCmd) begin mPhase = 0; mRdy = 0; end
      else if (startCmd) begin mCnt = pre; mPhase = 2; end
      else tickUse = tickEn;
    end
    if (tickUse) begin
      if (mPhase == 1) begin
        mCnt = pre; mPhase = 2;
      end else if (mPhase == 2) begin
        if (mCnt <= 1) begin mCnt = 0; mRdy = 1; mPhase = 0; end
        else mCnt = mCnt - 1;
      end
    end
  end

  // per-cycle comparison a quarter period after each edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    checks++;
    if (ctrReady !== mRdy || irqOut !== (mRdy & irqMask) ||
        {countHi, countLo} !== 16'(mCnt)) begin
      fails++;
      $display("FAIL %s model: ready=%0b irq=%0b count=%04h expected ready=%0b irq=%0b count=%04h",
               curReq, ctrReady, irqOut, {countHi, countLo}, mRdy, mRdy & irqMask, 16'(mCnt));
    end
  end

  task automatic chk(string req, bit expRdy, bit expIrq, int expCnt);
    checks++;
    if (ctrReady !== expRdy || irqOut !== expIrq || {countHi, countLo} !== 16'(expCnt)) begin
      fails++;
      $display("FAIL %s: ready=%0b irq=%0b count=%04h expected ready=%0b irq=%0b count=%04h",
               req, ctrReady, irqOut, {countHi, countLo}, expRdy, expIrq, 16'(expCnt));
    end
  endtask

  task automatic cyc(bit tk, bit push, bit cw, logic [3:0] op, bit st, bit sp);
    tickEn = tk; charPush = push; cmdWe = cw; cmdOp = op; startCmd = st; stopCmd = sp;
    @(negedge clk);
    tickEn = 0; charPush = 0; cmdWe = 0; cmdOp = 4'h0; startCmd = 0; stopCmd = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 4'h0, 0, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCH_LIMIT) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1"; chk("R1 reset state", 0, 0, 0);

    presetHi = 8'h00; presetLo = 8'h03; irqMask = 1'b1;
    curReq = "R9";
    cyc(0, 0, 0, 4'h0, 1, 0); chk("R9 start loads preset", 0, 0, 3);
    ticks(3);                 chk("R4 expiry normal mode", 1, 1, 0);
    ticks(2);                 chk("R4 holds at zero", 1, 1, 0);
    irqMask = 1'b0; @(negedge clk);
    curReq = "R5"; chk("R5 masked irq", 1, 0, 0);
    irqMask = 1'b1; @(negedge clk);
    chk("R5 unmasked irq", 1, 1, 0);
    curReq = "R9";
    cyc(0, 0, 0, 4'h0, 0, 1); chk("R9 stop clears ready", 0, 0, 0);
    cyc(0, 0, 0, 4'h0, 1, 0); ticks(1); cyc(0, 0, 0, 4'h0, 0, 1); ticks(2);
    chk("R9 stopped count holds", 0, 0, 2);

    curReq = "R2";
    cyc(0, 0, 0, 4'h0, 1, 0); ticks(3); chk("R2 ready set before arm", 1, 1, 0);
    cyc(0, 0, 1, 4'hA, 0, 0); chk("R2 arm clears ready", 0, 0, 0);
    ticks(3);                 chk("R2 parked until character", 0, 0, 0);

    curReq = "R3";
    cyc(0, 1, 0, 4'h0, 0, 0); chk("R3 push halts only", 0, 0, 0);
    ticks(1);                 chk("R3 first tick reloads", 0, 0, 3);
    ticks(1);                 chk("R3 decrement", 0, 0, 2);
    ticks(2);                 chk("R4 time-out sets ready", 1, 1, 0);

    curReq = "R6";
    cyc(0, 1, 0, 4'h0, 0, 0); chk("R6 character withdraws ready", 0, 0, 0);
    ticks(2); cyc(0, 1, 0, 4'h0, 0, 0); chk("R6 push mid-run", 0, 0, 2);
    ticks(1);                 chk("R6 restart reloads", 0, 0, 3);

    curReq = "R7";
    cyc(0, 0, 0, 4'h0, 0, 1); ticks(1); chk("R7 stop ignored", 0, 0, 2);
    cyc(0, 0, 0, 4'h0, 1, 0); chk("R7 start ignored", 0, 0, 2);
    ticks(1);                 chk("R7 still counting", 0, 0, 1);

    curReq = "R10";
    cyc(0, 1, 1, 4'hA, 0, 0); ticks(2); chk("R10 command beats push", 0, 0, 1);

    curReq = "R8";
    cyc(0, 0, 1, 4'hC, 0, 0); cyc(0, 1, 0, 4'h0, 0, 0); ticks(2);
    chk("R8 push ignored when off", 0, 0, 1);
    cyc(0, 0, 0, 4'h0, 1, 0); chk("R8 start acts again", 0, 0, 3);

    curReq = "R10";
    cyc(0, 0, 0, 4'h0, 1, 1); ticks(1); chk("R10 stop beats start", 0, 0, 3);

    curReq = "R11";
    presetHi = 8'h12; presetLo = 8'h34;
    cyc(0, 0, 0, 4'h0, 1, 0); chk("R11 byte split", 0, 0, 16'h1234);
    ticks(1);                 chk("R11 low byte step", 0, 0, 16'h1233);
    presetHi = 8'h01; presetLo = 8'h00;
    cyc(0, 0, 0, 4'h0, 1, 0); ticks(1); chk("R11 borrow across bytes", 0, 0, 16'h00FF);

    curReq = "R4";
    presetHi = 8'h00; presetLo = 8'h00;
    cyc(0, 0, 1, 4'hA, 0, 0); cyc(0, 1, 0, 4'h0, 0, 0); ticks(1);
    chk("R4 zero preset reload", 0, 0, 0);
    ticks(1);                 chk("R4 zero preset expires", 1, 1, 0);

    // mixed stimulus, compared against the model every cycle
    curReq = "R3 mixed";
    presetLo = 8'h05;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      irqMask = (r % 7) != 0;
      if (r < 3) cyc(r[0], 0, 1, (r == 1) ? 4'hC : 4'hA, 0, 0);
      else if (r < 12) cyc(r[0], 1, 0, 4'h0, 0, 0);
      else if (r < 15) cyc(0, 0, 0, 4'h0, 1, 0);
      else if (r < 17) cyc(0, 0, 0, 4'h0, 0, 1);
      else cyc(r < 70, 0, 0, 4'h0, 0, 0);
    end
    @(negedge clk);
    finishRun();
  end

endmodule